// File: doc/BRIEF.md
# Sixteen-Bit Timer with One Compare Channel

The block is a 16-bit up-counter paired with a single output-compare channel, programmed over a narrow byte-wide register port. The counter advances by one on each cycle where the prescaler's tick input is high and the run bit is set. It either wraps through all-ones, which raises the overflow flag, or returns to zero after reaching the compare value. A match raises the compare flag and drives the compare output bit according to a two-bit action field. Software can also force the action without a match.

The counter and compare value are wider than the bus, so every 16-bit transfer passes through one shared holding byte. Reading the counter's low byte freezes the matching high byte into the holding byte. Writing a high byte stages it there, and the next low-byte write commits all sixteen bits in one clock. Any write of the counter suppresses the compare match on the timer tick that follows. This keeps a freshly loaded counter that equals the compare value from firing straight away.

Top module: `tmr16_oc`

Register map (3-bit address, 8-bit data): 0 counter low, 1 counter high (holding byte), 2 compare low, 3 compare high, 4 control, 5 flags, 6 force strobe (write only, reads 0), 7 unused (reads 0). Control bits: [1:0] output action (00 none, 01 toggle, 10 clear, 11 set), [2] clear-on-compare mode, [3] run. Flags bits: [0] compare flag, [1] overflow flag.

## Requirements
- R1: After a synchronous reset, the counter, compare value, control, holding byte, read data, compare output and both flags are all zero.
- R2: A read of address 0 returns the counter's low byte and copies its high byte into the holding byte. A read of address 1 returns the holding byte, even if the counter has moved since.
- R3: A write to address 1 or 3 loads the holding byte. A write to address 0 (counter) or 2 (compare) then loads {holding byte, data} in one clock. Addresses 2 and 3 read the compare bytes directly.
- R4: With control bit 3 set and tick high, the counter advances by one per clock. Otherwise it holds. A counter write in the same clock as a tick wins over the count.
- R5: In normal mode (control bit 2 clear), a tick at FFFFh takes the counter to 0000h and sets the overflow flag (flags bit 1).
- R6: A tick while the counter equals the compare value sets the compare flag (flags bit 0) at that clock edge. In clear-on-compare mode (control bit 2 set), the counter goes to 0 on that tick instead of advancing.
- R7: On a match, the compare output follows control bits [1:0]: 00 unchanged, 01 inverted, 10 cleared, 11 set. The field in force at the match is the one used.
- R8: Writing 1 to a flags bit clears that flag, and writing 0 leaves it. A pulse on cmp_ack clears the compare flag. A flag set in the same clock wins over the clear.
- R9: Writing 1 to bit 0 of address 6 applies the output action at once. It leaves the compare flag and the counter unchanged.
- R10: After a counter write, the first tick that advances the counter produces no match (no flag, no output action, no clear), even if the timer was stopped in between. Later ticks match normally.
- R11: Address 4 reads back control bits [3:0], address 5 reads back {overflow, compare} in bits [1:0], and addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after reg_rd |
| tick | input | 1 | Timer clock enable from the prescaler |
| cmp_ack | input | 1 | Compare interrupt acknowledge, clears the compare flag |
| cmp_out | output | 1 | Compare output bit |
| cmp_flag | output | 1 | Compare flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The properties assume that reg_rd and reg_wr are never high together, and that the force strobe is never issued on a clock where a tick advances the counter. Under either condition, a concurrent match or clear would make the next-cycle expectation ambiguous. The stimulus keeps bus accesses and ticks in separate clocks, except in the two cases that deliberately combine them: a counter write coinciding with a tick, and an acknowledge coinciding with a matching tick. Neither case falls under a property whose precondition excludes it.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    RA_CNT_LO = 3'd0,
    RA_CNT_HI = 3'd1,
    RA_CMP_LO = 3'd2,
    RA_CMP_HI = 3'd3,
    RA_CTRL   = 3'd4,
    RA_FLAGS  = 3'd5,
    RA_FORCE  = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } out_act_e;

  typedef struct packed {
    logic     run;
    logic     ctc;
    out_act_e act;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr16_regif.sv
module tmr16_regif
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_flag,
  input  logic             ovf_flag,
  output logic [BUS_W-1:0] rdata,
  output logic [CNT_W-1:0] cmp_q,
  output ctrl_t            ctrl_q,
  output logic             cnt_ld,
  output logic [CNT_W-1:0] cnt_ld_val,
  output logic             force_stb,
  output logic             clr_cmp,
  output logic             clr_ovf
);

  logic [BUS_W-1:0] temp_q;
  logic [BUS_W-1:0] rd_mux;
  reg_addr_e        ra;

  assign ra = reg_addr_e'(addr);

  // strobes towards the counter and the compare logic
  assign cnt_ld     = wr && (ra == RA_CNT_LO);
  assign cnt_ld_val = {temp_q, wdata};
  assign force_stb  = wr && (ra == RA_FORCE) && wdata[0];
  assign clr_cmp    = wr && (ra == RA_FLAGS) && wdata[0];
  assign clr_ovf    = wr && (ra == RA_FLAGS) && wdata[1];

  always_comb begin
    rd_mux = '0;
    case (ra)
      RA_CNT_LO: rd_mux = cnt[BUS_W-1:0];
      RA_CNT_HI: rd_mux = temp_q;
      RA_CMP_LO: rd_mux = cmp_q[BUS_W-1:0];
      RA_CMP_HI: rd_mux = cmp_q[CNT_W-1:BUS_W];
      RA_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      RA_FLAGS:  rd_mux[1:0] = {ovf_flag, cmp_flag};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
      cmp_q  <= '0;
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd) begin
        rdata <= rd_mux;
        if (ra == RA_CNT_LO) temp_q <= cnt[CNT_W-1:BUS_W];
      end
      if (wr) begin
        case (ra)
          RA_CNT_HI, RA_CMP_HI: temp_q <= wdata;
          RA_CMP_LO:            cmp_q  <= {temp_q, wdata};
          RA_CTRL:              ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ctc,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blk_q,
  output logic             match_evt,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic adv;
  logic hit;
  logic at_top;

  // a bus write to the counter has priority over counting
  assign adv       = run && tick && !cnt_ld;
  assign hit       = (cnt_q == cmp_val);
  assign at_top    = &cnt_q;
  assign match_evt = adv && hit && !blk_q;
  assign wrap_evt  = adv && at_top && !(ctc && match_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      if (cnt_ld) begin
        cnt_q <= cnt_ld_val;
        blk_q <= 1'b1;
      end else if (adv) begin
        blk_q <= 1'b0;
        if (ctc && match_evt) cnt_q <= '0;
        else                  cnt_q <= cnt_q + ONE;
      end
    end
  end

endmodule

// File: rtl/tmr16_outcmp.sv
module tmr16_outcmp
  import tmr16_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  out_act_e act,
  input  logic     match_evt,
  input  logic     force_stb,
  input  logic     wrap_evt,
  input  logic     clr_cmp,
  input  logic     clr_ovf,
  input  logic     ack,
  output logic     cmp_out,
  output logic     cmp_flag,
  output logic     ovf_flag
);

  logic fire;
  logic out_nxt;

  assign fire = match_evt || force_stb;

  always_comb begin
    out_nxt = cmp_out;
    if (fire) begin
      case (act)
        ACT_TOGGLE: out_nxt = !cmp_out;
        ACT_CLEAR:  out_nxt = 1'b0;
        ACT_SET:    out_nxt = 1'b1;
        default:    out_nxt = cmp_out;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_out  <= 1'b0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_out <= out_nxt;
      if (match_evt)            cmp_flag <= 1'b1;
      else if (clr_cmp || ack)  cmp_flag <= 1'b0;
      if (wrap_evt)             ovf_flag <= 1'b1;
      else if (clr_ovf)         ovf_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr16_oc.sv
module tmr16_oc
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             tick,
  input  logic             cmp_ack,
  output logic             cmp_out,
  output logic             cmp_flag,
  output logic             ovf_flag
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_ld_val;
  ctrl_t            ctrl_q;
  logic             cnt_ld;
  logic             force_stb;
  logic             clr_cmp;
  logic             clr_ovf;
  logic             blk_q;
  logic             match_evt;
  logic             wrap_evt;
  logic             run_w;
  logic             ctc_w;

  assign run_w = ctrl_q.run;
  assign ctc_w = ctrl_q.ctc;

  tmr16_regif #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .addr       (reg_addr),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .wdata      (reg_wdata),
    .cnt        (cnt_q),
    .cmp_flag   (cmp_flag),
    .ovf_flag   (ovf_flag),
    .rdata      (reg_rdata),
    .cmp_q      (cmp_q),
    .ctrl_q     (ctrl_q),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .force_stb  (force_stb),
    .clr_cmp    (clr_cmp),
    .clr_ovf    (clr_ovf)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (run_w),
    .tick       (tick),
    .ctc        (ctc_w),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .cmp_val    (cmp_q),
    .cnt_q      (cnt_q),
    .blk_q      (blk_q),
    .match_evt  (match_evt),
    .wrap_evt   (wrap_evt)
  );

  tmr16_outcmp u_out (
    .clk       (clk),
    .rst       (rst),
    .act       (ctrl_q.act),
    .match_evt (match_evt),
    .force_stb (force_stb),
    .wrap_evt  (wrap_evt),
    .clr_cmp   (clr_cmp),
    .clr_ovf   (clr_ovf),
    .ack       (cmp_ack),
    .cmp_out   (cmp_out),
    .cmp_flag  (cmp_flag),
    .ovf_flag  (ovf_flag)
  );

endmodule

// File: rtl/tmr16_oc_chk.sv
module tmr16_oc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             cmp_ack,
  input logic             run,
  input logic             ctc,
  input logic             cnt_ld,
  input logic             force_stb,
  input logic             blk,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cmp_out,
  input logic             cmp_flag,
  input logic             ovf_flag
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1: everything quiet the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!cmp_out && !cmp_flag && !ovf_flag && cnt == '0));

  // R4: no tick or not running, no write -> counter holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && !(run && tick)) |=> (cnt == $past(cnt)));

  // R4: normal-mode advance by one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && run && tick && !ctc) |=> (cnt == $past(cnt) + ONE));

  // R5: wrap from all-ones raises the overflow flag
  p_wrap_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && run && tick && !ctc && (&cnt)) |=> ovf_flag);

  // R6: unblocked equality on a tick raises the compare flag
  p_match_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && run && tick && !blk && cnt == cmp) |=> cmp_flag);

  // R6: clear-on-compare returns the counter to zero
  p_ctc_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && run && tick && ctc && !blk && cnt == cmp) |=> (cnt == '0));

  // R8: acknowledge clears the compare flag when no match can occur
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_ack && !(run && tick)) |=> !cmp_flag);

  // R9: forcing never sets the flag
  p_force_noflag_r9: assert property (@(posedge clk) disable iff (rst)
    (force_stb && !(run && tick) && !cmp_flag) |=> !cmp_flag);

  // R10: the blocked tick leaves the output untouched
  p_block_out_r10: assert property (@(posedge clk) disable iff (rst)
    (blk && run && tick && !cnt_ld && !force_stb) |=> $stable(cmp_out));

  // R10: the blocked tick cannot raise the flag
  p_block_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (blk && run && tick && !cnt_ld && !cmp_flag) |=> !cmp_flag);

endmodule

bind tmr16_oc tmr16_oc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .cmp_ack   (cmp_ack),
  .run       (run_w),
  .ctc       (ctc_w),
  .cnt_ld    (cnt_ld),
  .force_stb (force_stb),
  .blk       (blk_q),
  .cnt       (cnt_q),
  .cmp       (cmp_q),
  .cmp_out   (cmp_out),
  .cmp_flag  (cmp_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_tmr16_oc.sv
`timescale 1ns/1ps
module sim_tmr16_oc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic       cmp_ack = 1'b0;
  logic       cmp_out;
  logic       cmp_flag;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = !clk;

  tmr16_oc #(.BUS_W(8)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick), .cmp_ack(cmp_ack),
    .cmp_out(cmp_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd1, v[15:8]);
    wr(3'd0, v[7:0]);
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(3'd3, v[15:8]);
    wr(3'd2, v[7:0]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic        prev;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state at ports and through the bus
    check("R1 cmp_out", cmp_out, 0);
    check("R1 cmp_flag", cmp_flag, 0);
    check("R1 ovf_flag", ovf_flag, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], b);
      check("R1 register reads zero", b, 0);
    end

    // R3: staged 16-bit writes of counter and compare
    set_cnt(16'h1234);
    rd16(v);
    check("R3 counter load", v, 16'h1234);
    set_cmp(16'hCDAB);
    rd(3'd2, b); check("R3 compare low", b, 8'hAB);
    rd(3'd3, b); check("R3 compare high", b, 8'hCD);

    // R2: holding byte frozen by the low-byte read
    set_cnt(16'h00FF);
    wr(3'd4, 8'h08);
    rd(3'd0, b); check("R2 low byte", b, 8'hFF);
    ticks(1);
    rd(3'd1, b); check("R2 high byte from holding", b, 8'h00);
    rd16(v); check("R2 fresh 16-bit read", v, 16'h0100);

    // R4: stopped, idle, running
    wr(3'd4, 8'h00);
    ticks(5);
    rd16(v); check("R4 stopped holds", v, 16'h0100);
    wr(3'd4, 8'h08);
    repeat (4) @(negedge clk);
    rd16(v); check("R4 no tick holds", v, 16'h0100);
    ticks(7);
    rd16(v); check("R4 seven ticks", v, 16'h0107);
    wr(3'd1, 8'h40);
    wr_tick(3'd0, 8'h00);
    rd16(v); check("R4 write beats count", v, 16'h4000);

    // R5: wrap and overflow flag; R8 flag clearing rules
    set_cmp(16'h8000);
    set_cnt(16'hFFFE);
    ticks(1);
    check("R5 no flag before wrap", ovf_flag, 0);
    ticks(1);
    check("R5 overflow flag", ovf_flag, 1);
    rd16(v); check("R5 wrapped to zero", v, 16'h0000);
    rd(3'd5, b); check("R11 flags readback", b, 8'h02);
    wr(3'd5, 8'h01); check("R8 other bit no effect", ovf_flag, 1);
    wr(3'd5, 8'h00); check("R8 zero write no effect", ovf_flag, 1);
    wr(3'd5, 8'h02); check("R8 write-one clears", ovf_flag, 0);

    // R6 R7 R9: sweep start level and action field
    for (int init = 0; init < 2; init++) begin
      for (int act = 0; act < 4; act++) begin
        logic exp_out;
        wr(3'd5, 8'h03);
        wr(3'd4, init ? 8'h0B : 8'h0A);
        wr(3'd6, 8'h01);
        check("R9 force sets start level", cmp_out, init[0]);
        wr(3'd4, 8'h08 | act[7:0]);
        set_cmp(16'h0010);
        set_cnt(16'h000C);
        ticks(4);
        check("R6 no flag before match", cmp_flag, 0);
        check("R7 output before match", cmp_out, init[0]);
        ticks(1);
        check("R6 flag on match", cmp_flag, 1);
        case (act)
          0: exp_out = init[0];
          1: exp_out = !init[0];
          2: exp_out = 1'b0;
          default: exp_out = 1'b1;
        endcase
        check("R7 action on match", cmp_out, exp_out);
        rd16(v); check("R6 normal mode keeps counting", v, 16'h0011);
      end
    end

    // R6: clear-on-compare period sweep
    for (int c = 1; c <= 6; c++) begin
      wr(3'd4, 8'h0C);
      wr(3'd5, 8'h03);
      set_cmp(c[15:0]);
      set_cnt(16'h0000);
      ticks(c);
      rd16(v); check("R6 reaches compare", v, c[15:0]);
      check("R6 no early flag", cmp_flag, 0);
      ticks(1);
      rd16(v); check("R6 clears to zero", v, 16'h0000);
      check("R6 flag in ctc", cmp_flag, 1);
      check("R5 no overflow in ctc", ovf_flag, 0);
    end

    // R8: acknowledge clears, set wins over acknowledge
    @(negedge clk); cmp_ack = 1'b1;
    @(negedge clk); cmp_ack = 1'b0;
    check("R8 ack clears", cmp_flag, 0);
    set_cnt(16'h0005);
    ticks(1);
    @(negedge clk); cmp_ack = 1'b1; tick = 1'b1;
    @(negedge clk); cmp_ack = 1'b0; tick = 1'b0;
    check("R8 set wins over ack", cmp_flag, 1);
    @(negedge clk); cmp_ack = 1'b1;
    @(negedge clk); cmp_ack = 1'b0;
    check("R8 ack clears again", cmp_flag, 0);

    // R9: force toggles without flag or counter change
    wr(3'd4, 8'h0D);
    set_cnt(16'h0003);
    prev = cmp_out;
    wr(3'd6, 8'h01);
    check("R9 force toggles", cmp_out, !prev);
    check("R9 no flag", cmp_flag, 0);
    rd16(v); check("R9 counter untouched", v, 16'h0003);
    wr(3'd6, 8'h00);
    check("R9 bit0 clear no force", cmp_out, !prev);

    // R10: blocked match even across a stopped interval
    wr(3'd4, 8'h02);
    wr(3'd6, 8'h01);
    wr(3'd4, 8'h03);
    wr(3'd5, 8'h03);
    set_cmp(16'h0020);
    set_cnt(16'h0020);
    ticks(3);
    repeat (5) @(negedge clk);
    wr(3'd4, 8'h0B);
    ticks(1);
    check("R10 blocked flag", cmp_flag, 0);
    check("R10 blocked output", cmp_out, 0);
    rd16(v); check("R10 counter advanced", v, 16'h0021);
    set_cnt(16'h001F);
    ticks(1);
    check("R10 still no flag", cmp_flag, 0);
    ticks(1);
    check("R10 second tick matches", cmp_flag, 1);
    check("R10 second tick output", cmp_out, 1);
    wr(3'd4, 8'h0C);
    wr(3'd5, 8'h03);
    set_cnt(16'h0020);
    ticks(1);
    rd16(v); check("R10 blocked ctc no clear", v, 16'h0021);
    check("R10 blocked ctc no flag", cmp_flag, 0);

    // R11: control and spare readback
    rd(3'd4, b); check("R11 control readback", b, 8'h0C);
    rd(3'd6, b); check("R11 force reads zero", b, 8'h00);
    rd(3'd7, b); check("R11 spare reads zero", b, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule